// File: doc/BRIEF.md
# Configuration Memory Reset Sequencer

This block decides when a serial configuration memory may leave reset and when it must return to it. It reads digital flags from external voltage monitors: the core supply is above its power-on level, the core supply has dropped below its lower power-down level, and the output supply is within its operating range. It also reads an active-low chip-enable input and the sampled level of the shared open-drain reset/output-enable line.

While supplies ramp, the block pulls the reset line low. Once every required flag holds for a programmable number of clock cycles, it lets the line go. When the line is released, the block picks standby, reset or active operation from the chip-enable input and the line level it samples back. The line level passes through a two-flop synchroniser, so an outside agent that keeps the released line low extends the reset.

Because the two supply thresholds differ, the block has hysteresis. After release, only the power-down flag sends it back to the power-down state. A parameter sets whether the output supply must also be valid before release. The line is always active-low.

Top module: `cfgmem_rst_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `state_o` reads 0 (power-down) and `pin_drive_low` is 1.
- R2: Release waits for exactly DLY_CYCLES consecutive cycles in state 1 (delay wait) with all required supply flags true. `pin_drive_low` stays 1 for all of those cycles and falls only after them.
- R3: With REQUIRE_VIO=1, the default, the block stays in state 0 while `vio_ok` is 0, even when `core_por_ok` is 1.
- R4: When `core_pd_low` is 1, the next state is 0 from any state, with `pin_drive_low`=1. The block stays in state 0 until `core_por_ok` is 1 again.
- R5: When powered, with `chip_en_n`=0 and the synchronised line low, the state is 2 (reset). In that state `addr_clr`=1, `cascade_en_n`=1 and `data_oe`=0.
- R6: When powered, with `chip_en_n`=1, the state is 3 (standby) whatever the line level. Outputs are as in R5, and `pin_drive_low`=0.
- R7: When powered, with `chip_en_n`=0 and the line high, the state is 4 (active). In that state `addr_clr`=0, `cascade_en_n`=0 and `data_oe`=1.
- R8: An outside agent that holds the released line low moves the block to state 2 within three cycles. When the agent lets go, the block returns to state 4.
- R9: If any required supply flag drops during state 1, the block goes back to state 0. The next delay wait then takes the full DLY_CYCLES again.
- R10: After release, `core_por_ok` falling to 0 with `core_pd_low`=0 does not leave the powered states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_por_ok | input | 1 | Core supply above power-on level |
| core_pd_low | input | 1 | Core supply below power-down level |
| vio_ok | input | 1 | Output supply in operating range |
| chip_en_n | input | 1 | Chip enable, active low; high selects standby |
| pin_in | input | 1 | Sampled level of the open-drain reset line |
| pin_drive_low | output | 1 | Pull the reset line low |
| addr_clr | output | 1 | Clear the address counter |
| cascade_en_n | output | 1 | Cascade enable, high while not active |
| data_oe | output | 1 | Tristate enable for data outputs |
| state_o | output | 3 | State code: 0 power-down, 1 delay wait, 2 reset, 3 standby, 4 active |

## Verification
Standby and a low reset line can occur in the same cycle. The bench provokes this by raising `chip_en_n` while an outside hold pulls the line low, and it expects standby. A power-down flag can also arrive together with chip-enable high. Here the bench expects the power-down state and a driven line. A directed test counts the delay-wait cycles, both on a clean ramp and after a supply glitch that restarts the count.

// File: rtl/cfgmem_rst_pkg.sv
package cfgmem_rst_pkg;

    typedef enum logic [2:0] {
        ST_PWR_DOWN = 3'd0,
        ST_WAIT_DLY = 3'd1,
        ST_RESET    = 3'd2,
        ST_STANDBY  = 3'd3,
        ST_ACTIVE   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic drv_low;
        logic addr_clr;
        logic casc_n;
        logic data_oe;
    } pin_ctl_t;

    // choose among the powered states
    function automatic seq_state_e pick_powered(input logic cen_n, input logic line_low);
        if (cen_n)
            return ST_STANDBY;
        else if (line_low)
            return ST_RESET;
        else
            return ST_ACTIVE;
    endfunction

    function automatic pin_ctl_t decode_ctl(input seq_state_e s);
        pin_ctl_t c;
        c.drv_low  = (s == ST_PWR_DOWN) || (s == ST_WAIT_DLY);
        c.addr_clr = (s != ST_ACTIVE);
        c.casc_n   = (s != ST_ACTIVE);
        c.data_oe  = (s == ST_ACTIVE);
        return c;
    endfunction

endpackage

// File: rtl/cfgmem_supply_gate.sv
module cfgmem_supply_gate #(
    parameter bit REQUIRE_VIO = 1'b1
) (
    input  logic core_por_ok,
    input  logic core_pd_low,
    input  logic vio_ok,
    output logic sup_ok
);
    generate
        if (REQUIRE_VIO) begin : g_with_vio
            assign sup_ok = core_por_ok & vio_ok & ~core_pd_low;
        end else begin : g_core_only
            logic unused_vio;
            assign unused_vio = vio_ok;
            assign sup_ok = core_por_ok & ~core_pd_low;
        end
    endgenerate
endmodule

// File: rtl/cfgmem_release_timer.sv
module cfgmem_release_timer #(
    parameter int DLY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic done
);
    localparam int CW = (DLY_CYCLES > 2) ? $clog2(DLY_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = en && (cnt_q == LAST);

    // restart from zero whenever the enable drops
    assert_timer_restart_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));
endmodule

// File: rtl/cfgmem_line_sync.sv
module cfgmem_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic line_low
);
    logic s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= pin_in;
            s2_q <= s1_q;
        end
    end

    assign line_low = ~s2_q;

    assert_sync_chain_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (s2_q == $past(s1_q)));
endmodule

// File: rtl/cfgmem_rst_seq.sv
module cfgmem_rst_seq
    import cfgmem_rst_pkg::*;
#(
    parameter int DLY_CYCLES  = 64,
    parameter bit REQUIRE_VIO = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       core_por_ok,
    input  logic       core_pd_low,
    input  logic       vio_ok,
    input  logic       chip_en_n,
    input  logic       pin_in,
    output logic       pin_drive_low,
    output logic       addr_clr,
    output logic       cascade_en_n,
    output logic       data_oe,
    output logic [2:0] state_o
);
    seq_state_e st_q, st_nx;
    logic       sup_ok, tmr_done, line_low, tmr_en;
    pin_ctl_t   ctl;

    cfgmem_supply_gate #(.REQUIRE_VIO(REQUIRE_VIO)) u_gate (
        .core_por_ok (core_por_ok),
        .core_pd_low (core_pd_low),
        .vio_ok      (vio_ok),
        .sup_ok      (sup_ok)
    );

    assign tmr_en = (st_q == ST_WAIT_DLY) && sup_ok;

    cfgmem_release_timer #(.DLY_CYCLES(DLY_CYCLES)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .en   (tmr_en),
        .done (tmr_done)
    );

    cfgmem_line_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .line_low (line_low)
    );

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_PWR_DOWN: if (sup_ok) st_nx = ST_WAIT_DLY;
            ST_WAIT_DLY: begin
                if (!sup_ok)
                    st_nx = ST_PWR_DOWN;
                else if (tmr_done)
                    st_nx = pick_powered(chip_en_n, line_low);
            end
            default: st_nx = pick_powered(chip_en_n, line_low);
        endcase
        if (core_pd_low)
            st_nx = ST_PWR_DOWN;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= ST_PWR_DOWN;
        else
            st_q <= st_nx;
    end

    assign ctl           = decode_ctl(st_q);
    assign pin_drive_low = ctl.drv_low;
    assign addr_clr      = ctl.addr_clr;
    assign cascade_en_n  = ctl.casc_n;
    assign data_oe       = ctl.data_oe;
    assign state_o       = st_q;

    assert_pd_forces_down_R4: assert property (@(posedge clk) disable iff (rst)
        core_pd_low |=> (st_q == ST_PWR_DOWN && pin_drive_low));

    assert_release_after_delay_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_drive_low) |-> $past(tmr_done));

    assert_vio_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (REQUIRE_VIO && st_q == ST_PWR_DOWN && !vio_ok) |=> (st_q == ST_PWR_DOWN));

    assert_standby_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q inside {ST_RESET, ST_STANDBY, ST_ACTIVE} && chip_en_n && !core_pd_low)
        |=> (st_q == ST_STANDBY));

    assert_no_drive_when_on_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q inside {ST_RESET, ST_STANDBY, ST_ACTIVE} && !core_pd_low) |=> !pin_drive_low);

    assert_quiet_outputs_R5: assert property (@(posedge clk) disable iff (rst)
        cascade_en_n |-> !data_oe);
endmodule

// File: tb/cfgmem_rst_seq_tb.sv
module cfgmem_rst_seq_tb_top;
    localparam int D = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic core_por_ok = 1'b0, core_pd_low = 1'b0, vio_ok = 1'b0, chip_en_n = 1'b0;
    logic ext_hold = 1'b0;
    logic pin_in, pin_drive_low, addr_clr, cascade_en_n, data_oe;
    logic [2:0] state_o;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign pin_in = ~(pin_drive_low | ext_hold);

    cfgmem_rst_seq #(.DLY_CYCLES(D), .REQUIRE_VIO(1'b1)) dut_i (
        .clk(clk), .rst(rst), .core_por_ok(core_por_ok), .core_pd_low(core_pd_low),
        .vio_ok(vio_ok), .chip_en_n(chip_en_n), .pin_in(pin_in),
        .pin_drive_low(pin_drive_low), .addr_clr(addr_clr), .cascade_en_n(cascade_en_n),
        .data_oe(data_oe), .state_o(state_o)
    );

    // fields: por, pd, vio, cen_n, hold, wait[4:0], expected state[2:0], requirement[3:0]
    localparam int NV = 14;
    localparam logic [16:0] VEC [0:NV-1] = '{
        {5'b10000, 5'd10, 3'd0, 4'd3},   // R3 no output supply
        {5'b10100, 5'd12, 3'd4, 4'd7},   // R7 released, active
        {5'b10110, 5'd3,  3'd3, 4'd6},   // R6 standby
        {5'b10111, 5'd5,  3'd3, 4'd6},   // R6 standby beats low line
        {5'b10101, 5'd4,  3'd2, 4'd8},   // R8 outside hold
        {5'b10100, 5'd4,  3'd4, 4'd8},   // R8 hold let go
        {5'b01100, 5'd2,  3'd0, 4'd4},   // R4 power-down
        {5'b00100, 5'd5,  3'd0, 4'd4},   // R4 stays down without por
        {5'b10100, 5'd2,  3'd1, 4'd2},   // R2 delay wait
        {5'b10000, 5'd2,  3'd0, 4'd9},   // R9 glitch aborts wait
        {5'b10100, 5'd3,  3'd1, 4'd9},   // R9 restarted wait
        {5'b10100, 5'd10, 3'd4, 4'd7},   // R7 active again
        {5'b00100, 5'd3,  3'd4, 4'd10},  // R10 hysteresis
        {5'b01110, 5'd2,  3'd0, 4'd4}    // R4 power-down beats standby
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req, input int es);
        chk(req, "state", state_o, es);
        chk(req, "pin_drive_low", pin_drive_low, (es == 0 || es == 1) ? 1 : 0);
        chk(req, "addr_clr", addr_clr, (es == 4) ? 0 : 1);
        chk(req, "cascade_en_n", cascade_en_n, (es == 4) ? 0 : 1);
        chk(req, "data_oe", data_oe, (es == 4) ? 1 : 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        core_por_ok = 1'b0; core_pd_low = 1'b0; vio_ok = 1'b0; chip_en_n = 1'b0; ext_hold = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // count cycles spent in delay wait until leaving it
    task automatic count_wait(output int n);
        n = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (state_o == 3'd1) n++;
            else if (n > 0) break;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk_outputs("R1", 0);
        rst = 1'b0;
        @(negedge clk);
        chk_outputs("R1", 0);

        for (int i = 0; i < NV; i++) begin
            {core_por_ok, core_pd_low, vio_ok, chip_en_n, ext_hold} = VEC[i][16:12];
            repeat (int'(VEC[i][11:7])) @(negedge clk);
            chk_outputs($sformatf("R%0d", VEC[i][3:0]), int'(VEC[i][6:4]));
        end

        // R2: exact delay on a clean ramp
        do_reset();
        core_por_ok = 1'b1; vio_ok = 1'b1;
        count_wait(n);
        chk("R2", "wait cycles", n, D);
        chk("R2", "state after wait", state_o, 2);

        // R9: glitch mid-wait restarts the full count
        do_reset();
        core_por_ok = 1'b1; vio_ok = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9", "state mid wait", state_o, 1);
        vio_ok = 1'b0;
        @(negedge clk);
        chk("R9", "state after glitch", state_o, 0);
        vio_ok = 1'b1;
        count_wait(n);
        chk("R9", "wait cycles after restart", n, D);

        // R1: reset while active
        repeat (6) @(negedge clk);
        chk("R7", "state before reset", state_o, 4);
        rst = 1'b1;
        @(negedge clk);
        chk_outputs("R1", 0);
        rst = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule